// File: doc/BRIEF.md
# HDLC Transmit Framer with Tagged Byte Queue

This block turns a stream of host-written bytes into a bit-oriented HDLC line signal. Each byte enters a small queue together with two tag bits. One tag says the byte closes its packet. The other says the byte is to be replaced by an abort. The serializer moves one bit per cycle in which the bit strobe is high. It frames each packet with flags, stuffs zeros into the data and check field, and appends a 16-bit frame check sequence. When the queue runs dry in the middle of a packet it sends an abort pattern.

Between packets the line rests in a state the host selects: steady ones or repeated flags. A closing flag doubles as the opening flag of a packet that is already queued. A transparent mode sends queued bytes raw, with no protocol processing. Two one-cycle pulses report a completed packet and an underrun.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `tx_bit` is 1, `eop_sent` and `underrun` are 0, and the queue is empty, so the line sends steady ones while `idle_flags` is 0.
- R2: A packet goes out as the flag 01111110, then its data bytes, then the check sequence, then another flag. Every byte is sent least significant bit first.
- R3: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, processed in bit-reversed form (0x8408). The register starts at 0xFFFF, and its ones' complement is sent low byte first, each bit least significant first.
- R4: Within data and check-sequence bits, a 0 is inserted after every run of five consecutive 1s, including a run that ends on the last check bit.
- R5: If the queue holds data when a closing flag ends, the next packet's first data byte follows at once, with no second flag between the packets.
- R6: If a packet byte without the end tag was the last byte sent and the queue is empty, the block sends 0 followed by seven 1s. It pulses `underrun` for one cycle and then returns to the selected idle state.
- R7: A byte written with `wr_abort` set, reaching the queue head after at least two bytes of the current packet were sent, is discarded. The abort pattern goes out in its place, and the next queued byte starts a new packet with an opening flag. `underrun` is not pulsed.
- R8: An abort tag on a byte that would be the first or second byte of its packet is ignored, and the byte is sent as ordinary data.
- R9: When the queue holds FIFO_DEPTH entries, a write replaces the newest entry (data and tags) instead of being added.
- R10: With an empty queue outside a packet, the line sends 1s when `idle_flags` is 0 and back-to-back flags when it is 1. A packet queued during flag idle starts with its first data byte right after a flag.
- R11: With `trans_mode` set, queued bytes go out raw, least significant bit first, with no flags, stuffing, check sequence or abort. The line sends 1s when the queue is empty, and neither pulse is raised.
- R12: `tx_bit` changes only in the cycle after `bit_en` is high. `eop_sent` is a single-cycle pulse once per packet, raised by the tick that sends the last bit of the closing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to queue |
| wr_eop | input | 1 | Tag: byte ends its packet |
| wr_abort | input | 1 | Tag: send an abort in place of this byte |
| trans_mode | input | 1 | 1 selects raw transmission without framing |
| idle_flags | input | 1 | Idle state: 0 steady ones, 1 repeated flags |
| bit_en | input | 1 | Bit strobe: advance the line by one bit |
| tx_bit | output | 1 | Serial line output |
| eop_sent | output | 1 | One-cycle pulse after a closing flag |
| underrun | output | 1 | One-cycle pulse when an underrun abort starts |

## Verification
Most internal faults show up in the serial stream within one byte time. A wrong ones count, bit counter or symbol choice misplaces a stuffed zero, shortens a flag or drops a byte, so the expected frame no longer appears anywhere in the captured stream. A corrupted CRC register stays hidden until the last check bits of the packet, and a wrong end or abort tag shows up at the packet boundary as a missing check field, a spurious abort or a missing `eop_sent` pulse. Each scenario therefore rebuilds the whole expected bit stream, stuffing included, and searches the capture for it.

// File: rtl/hdlc_tx_pkg.sv
// Shared types and helpers for the HDLC transmit framer.
// Assumes bytes are sent least significant bit first.
package hdlc_tx_pkg;

    // Kind of 8- or 16-bit symbol currently being shifted out
    typedef enum logic [2:0] {
        K_IDLE1, K_IDLEF, K_OPEN, K_DATA, K_FCS, K_CLOSE, K_ABORT, K_RAW
    } sym_kind_t;

    // One queued byte with its two tags
    typedef struct packed {
        logic       eop;
        logic       abrt;
        logic [7:0] data;
    } tx_entry_t;

    localparam logic [7:0]  FLAG_PAT  = 8'h7E;
    localparam logic [7:0]  ABORT_PAT = 8'hFE;   // LSB first: 0 then seven 1s
    localparam logic [15:0] CRC_POLY  = 16'h8408; // bit-reversed 0x1021
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;

    // Advance the bit-reversed CRC over one byte, LSB first
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
// Tagged byte queue. A write into a full queue replaces the newest entry.
// Assumes DEPTH is a power of two.
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  tx_entry_t wr_entry,
    input  logic      pop,
    output tx_entry_t head,
    output logic      empty,
    output logic [CW-1:0] fill
);
    tx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic            full, push_new, do_pop;

    assign full     = (fill == CW'(DEPTH));
    assign empty    = (fill == '0);
    assign push_new = wr_en && !full;
    assign do_pop   = pop && !empty;
    assign head     = mem[rd_ptr];

    // Storage: new slot normally, newest slot when full
    always_ff @(posedge clk) begin
        if (wr_en) mem[full ? AW'(wr_ptr - 1'b1) : wr_ptr] <= wr_entry;
    end

    // Pointer and fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_new) wr_ptr <= AW'(wr_ptr + 1'b1);
            if (do_pop)   rd_ptr <= AW'(rd_ptr + 1'b1);
            case ({push_new, do_pop})
                2'b10:   fill <= CW'(fill + 1'b1);
                2'b01:   fill <= CW'(fill - 1'b1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/hdlc_tx_serial.sv
// Symbol sequencer and bit serializer. Chooses the next 8- or 16-bit symbol
// at each symbol end, shifts it out LSB first on bit_en, stuffs zeros
// after five ones in data and check bits, and keeps the running CRC.
// Assumes the queue head is valid whenever empty is low.
module hdlc_tx_serial
    import hdlc_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      trans_mode,
    input  logic      idle_flags,
    input  tx_entry_t head,
    input  logic      empty,
    output logic      pop,
    output logic      tx_bit,
    output logic      eop_sent,
    output logic      underrun
);
    sym_kind_t   kind, nk;
    logic [15:0] sh, nsh, crc, ncrc;
    logic [3:0]  cnt;
    logic [2:0]  ones;
    logic [1:0]  pkt, npkt;
    logic        last_eop, neop;
    logic        stuff, last_bit, stuffable, sym_end, eop_done, uflow;
    sym_kind_t   idle_k;
    logic [15:0] idle_sh;

    assign stuff     = (ones == 3'd5);
    assign stuffable = (kind == K_DATA) || (kind == K_FCS);
    assign last_bit  = (cnt == ((kind == K_FCS) ? 4'd15 : 4'd7));
    assign sym_end   = bit_en && !stuff && last_bit;
    assign idle_k    = idle_flags ? K_IDLEF : K_IDLE1;
    assign idle_sh   = idle_flags ? {8'h00, FLAG_PAT} : 16'h00FF;

    // Next-symbol decision, evaluated at the end of each symbol
    always_comb begin
        nk = kind; nsh = sh; ncrc = crc; npkt = pkt; neop = last_eop;
        pop = 1'b0; uflow = 1'b0; eop_done = 1'b0;
        if (sym_end) begin
            eop_done = (kind == K_CLOSE);
            if (trans_mode) begin
                if (!empty) begin pop = 1'b1; nk = K_RAW; nsh = {8'h00, head.data}; end
                else begin nk = K_IDLE1; nsh = 16'h00FF; end
            end else begin
                unique case (kind)
                    K_DATA: begin
                        if (last_eop) begin
                            nk = K_FCS; nsh = ~crc;
                        end else if (empty) begin
                            nk = K_ABORT; nsh = {8'h00, ABORT_PAT}; uflow = 1'b1;
                        end else begin
                            pop = 1'b1;
                            if (head.abrt && pkt == 2'd2) begin
                                nk = K_ABORT; nsh = {8'h00, ABORT_PAT};
                            end else begin
                                nk   = K_DATA; nsh = {8'h00, head.data};
                                ncrc = crc_byte(crc, head.data);
                                npkt = (pkt == 2'd2) ? 2'd2 : 2'(pkt + 1'b1);
                                neop = head.eop;
                            end
                        end
                    end
                    K_FCS: begin nk = K_CLOSE; nsh = {8'h00, FLAG_PAT}; end
                    K_OPEN, K_CLOSE, K_IDLEF: begin
                        if (empty) begin nk = idle_k; nsh = idle_sh; end
                        else begin
                            pop  = 1'b1;
                            nk   = K_DATA; nsh = {8'h00, head.data};
                            ncrc = crc_byte(CRC_INIT, head.data);
                            npkt = 2'd1;
                            neop = head.eop;
                        end
                    end
                    default: begin
                        if (empty) begin nk = idle_k; nsh = idle_sh; end
                        else begin nk = K_OPEN; nsh = {8'h00, FLAG_PAT}; end
                    end
                endcase
            end
        end
    end

    // Status pulses: one cycle, raised only by a symbol-ending tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_sent <= 1'b0;
            underrun <= 1'b0;
        end else begin
            eop_sent <= eop_done;
            underrun <= uflow;
        end
    end

    // Bit shifting, zero stuffing and symbol load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= K_IDLE1; sh <= 16'h00FF; cnt <= '0; ones <= '0;
            crc <= CRC_INIT; pkt <= '0; last_eop <= 1'b0; tx_bit <= 1'b1;
        end else if (bit_en) begin
            if (stuff) begin
                tx_bit <= 1'b0;
                ones   <= '0;
            end else begin
                tx_bit <= sh[0];
                ones   <= (stuffable && sh[0]) ? 3'(ones + 1'b1) : 3'd0;
                if (last_bit) begin
                    kind <= nk; sh <= nsh; cnt <= '0;
                    crc <= ncrc; pkt <= npkt; last_eop <= neop;
                end else begin
                    sh  <= sh >> 1;
                    cnt <= 4'(cnt + 1'b1);
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_framer.sv
// Top of the HDLC transmit framer: tagged byte queue plus serializer.
// Assumes the host holds wr_en for one cycle per byte.
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int FILL_W = $clog2(FIFO_DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_eop,
    input  logic       wr_abort,
    input  logic       trans_mode,
    input  logic       idle_flags,
    input  logic       bit_en,
    output logic       tx_bit,
    output logic       eop_sent,
    output logic       underrun
);
    tx_entry_t          wr_entry, head;
    logic               empty, pop;
    logic [FILL_W-1:0]  fifo_fill;

    assign wr_entry = '{eop: wr_eop, abrt: wr_abort, data: wr_data};

    hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
        .pop(pop), .head(head), .empty(empty), .fill(fifo_fill)
    );

    hdlc_tx_serial u_serial (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .trans_mode(trans_mode),
        .idle_flags(idle_flags), .head(head), .empty(empty), .pop(pop),
        .tx_bit(tx_bit), .eop_sent(eop_sent), .underrun(underrun)
    );
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
// Property checker for hdlc_tx_framer, attached by bind.
module hdlc_tx_framer_chk #(
    parameter int DEPTH = 16,
    localparam int FW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          tx_bit,
    input logic          eop_sent,
    input logic          underrun,
    input logic [FW-1:0] fill
);
    // R12: end-of-packet pulse lasts a single cycle
    a_r12_eop_single: assert property (@(posedge clk) disable iff (!rst_n)
        eop_sent |=> !eop_sent);

    // R12: the line holds its value when no bit strobe came
    a_r12_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    // R12: status pulses come only from a strobed tick
    a_r12_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_sent || underrun) |-> $past(bit_en));

    // R6: an underrun abort never coincides with a completed packet
    a_r6_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(eop_sent && underrun));

    // R9: the queue never reports more entries than it holds
    a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit),
    .eop_sent(eop_sent), .underrun(underrun), .fill(fifo_fill)
);

// File: tb/test_hdlc_tx_framer.sv
module test_hdlc_tx_framer;
    localparam int DEPTH = 16;
    localparam int CAPN  = 2048;
    localparam int NROW  = 3;
    localparam logic [71:0] ROW_DATA [0:NROW-1] =
        '{72'h393837363534333231, 72'hFF7EFF, 72'hF05A};
    localparam int ROW_LEN [0:NROW-1] = '{9, 3, 2};

    logic clk = 0, rst_n = 0, wr_en = 0, wr_eop = 0, wr_abort = 0;
    logic trans_mode = 0, idle_flags = 0, bit_en = 0;
    logic [7:0] wr_data = 0;
    logic tx_bit, eop_sent, underrun;

    hdlc_tx_framer #(.FIFO_DEPTH(DEPTH)) i_hdlc_tx_framer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eop(wr_eop), .wr_abort(wr_abort), .trans_mode(trans_mode),
        .idle_flags(idle_flags), .bit_en(bit_en), .tx_bit(tx_bit),
        .eop_sent(eop_sent), .underrun(underrun)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0, n_cap = 0, n_ex = 0, st_ones = 0;
    int eop_cnt = 0, uf_cnt = 0, eop_run = 0, eop_run_max = 0;
    bit done = 0;
    logic en_d = 0;
    logic cap [0:CAPN-1];
    logic ex  [0:CAPN-1];
    logic [7:0] fb [0:16];

    // Capture each line bit one cycle after its strobe, away from the edge
    always @(posedge clk) en_d <= bit_en;
    always @(negedge clk) begin
        if (rst_n) begin
            if (en_d && n_cap < CAPN) begin cap[n_cap] = tx_bit; n_cap++; end
            if (eop_sent) begin eop_cnt++; eop_run++; end else eop_run = 0;
            if (eop_run > eop_run_max) eop_run_max = eop_run;
            if (underrun) uf_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic push(input logic b); ex[n_ex] = b; n_ex++; endtask
    task automatic push_raw(input logic [7:0] b);
        for (int i = 0; i < 8; i++) push(b[i]);
    endtask
    task automatic push_flag(); push_raw(8'h7E); endtask
    task automatic push_abort(); push(1'b0); for (int i = 0; i < 7; i++) push(1'b1); st_ones = 0; endtask
    task automatic push_sbyte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            push(b[i]);
            if (b[i]) begin
                st_ones++;
                if (st_ones == 5) begin push(1'b0); st_ones = 0; end
            end else st_ones = 0;
        end
    endtask
    // Stuffed body of fb[0..len-1], check sequence, closing flag
    task automatic add_frame(input int len);
        logic [15:0] c = 16'hFFFF;
        st_ones = 0;
        for (int i = 0; i < len; i++) begin push_sbyte(fb[i]); c = bcrc(c, fb[i]); end
        c = ~c;
        push_sbyte(c[7:0]);
        push_sbyte(c[15:8]);
        push_flag();
    endtask

    function automatic int find_ex();
        for (int s = 0; s + n_ex <= n_cap; s++) begin
            bit m = 1;
            for (int k = 0; k < n_ex; k++) if (cap[s+k] !== ex[k]) m = 0;
            if (m) return s;
        end
        return -1;
    endfunction

    function automatic bit tail_ones(input int n);
        if (n_cap < n) return 0;
        for (int k = n_cap - n; k < n_cap; k++) if (cap[k] !== 1'b1) return 0;
        return 1;
    endfunction

    task automatic ticks(input int n); repeat (n) @(negedge clk); endtask

    task automatic do_reset(input logic idl, input logic trn, input logic en);
        @(negedge clk);
        rst_n = 0; idle_flags = idl; trans_mode = trn; bit_en = en; wr_en = 0;
        ticks(3);
        rst_n = 1; n_cap = 0; n_ex = 0;
        eop_cnt = 0; uf_cnt = 0; eop_run = 0; eop_run_max = 0;
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic e, input logic a);
        @(negedge clk);
        wr_en = 1; wr_data = b; wr_eop = e; wr_abort = a;
        @(negedge clk);
        wr_en = 0; wr_eop = 0; wr_abort = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int pos;
        // R1: reset state
        do_reset(1'b0, 1'b0, 1'b1);
        #1;
        chk(tx_bit === 1'b1, "R1 tx_bit after reset", tx_bit, 1);
        chk(eop_sent === 1'b0 && underrun === 1'b0, "R1 pulses after reset", eop_sent + underrun, 0);
        ticks(40);
        chk(tail_ones(32), "R1 idle ones with empty queue", n_cap, 32);

        // Table walk: R2, R3, R4 frames, R10 idle ones, R12 pulse
        for (int r = 0; r < NROW; r++) begin
            do_reset(1'b0, 1'b0, 1'b1);
            for (int i = 0; i < ROW_LEN[r]; i++)
                wr_byte(ROW_DATA[r][8*i +: 8], i == ROW_LEN[r] - 1, 1'b0);
            ticks(ROW_LEN[r] * 12 + 120);
            n_ex = 0; push_flag();
            for (int i = 0; i < ROW_LEN[r]; i++) fb[i] = ROW_DATA[r][8*i +: 8];
            add_frame(ROW_LEN[r]);
            pos = find_ex();
            chk(pos >= 0, "R2 R3 R4 framed packet in stream", pos, 0);
            chk(eop_cnt == 1, "R12 one eop_sent per packet", eop_cnt, 1);
            chk(uf_cnt == 0, "R6 no underrun on complete packet", uf_cnt, 0);
            chk(tail_ones(24), "R10 idle ones after packet", n_cap, 24);
            chk(eop_run_max == 1, "R12 eop_sent one cycle wide", eop_run_max, 1);
        end

        // R5: two packets back to back share one flag
        do_reset(1'b0, 1'b0, 1'b1);
        wr_byte(8'hA1, 0, 0); wr_byte(8'hB2, 1, 0);
        wr_byte(8'hC3, 0, 0); wr_byte(8'hD4, 1, 0);
        ticks(160);
        n_ex = 0; push_flag();
        fb[0] = 8'hA1; fb[1] = 8'hB2; add_frame(2);
        fb[0] = 8'hC3; fb[1] = 8'hD4; add_frame(2);
        pos = find_ex();
        chk(pos >= 0, "R5 shared flag between packets", pos, 0);
        chk(eop_cnt == 2, "R5 two eop_sent pulses", eop_cnt, 2);

        // R6: underrun abort
        do_reset(1'b0, 1'b0, 1'b1);
        wr_byte(8'h12, 0, 0); wr_byte(8'h34, 0, 0);
        ticks(120);
        n_ex = 0; push_flag(); st_ones = 0;
        push_sbyte(8'h12); push_sbyte(8'h34); push_abort();
        pos = find_ex();
        chk(pos >= 0, "R6 abort pattern after underrun", pos, 0);
        chk(uf_cnt == 1, "R6 underrun pulse", uf_cnt, 1);
        chk(eop_cnt == 0, "R6 no eop_sent on aborted packet", eop_cnt, 0);
        chk(tail_ones(24), "R6 idle ones after underrun", n_cap, 24);

        // R7: tagged abort after two bytes, then a fresh packet
        do_reset(1'b0, 1'b0, 1'b1);
        wr_byte(8'h11, 0, 0); wr_byte(8'h22, 0, 0);
        wr_byte(8'h33, 0, 1); wr_byte(8'h44, 1, 0);
        ticks(200);
        n_ex = 0; push_flag(); st_ones = 0;
        push_sbyte(8'h11); push_sbyte(8'h22); push_abort(); push_flag();
        fb[0] = 8'h44; add_frame(1);
        pos = find_ex();
        chk(pos >= 0, "R7 abort replaces tagged byte", pos, 0);
        chk(uf_cnt == 0, "R7 no underrun pulse", uf_cnt, 0);
        chk(eop_cnt == 1, "R7 following packet completes", eop_cnt, 1);

        // R8: abort tag on second byte is ignored
        do_reset(1'b0, 1'b0, 1'b1);
        wr_byte(8'h55, 0, 0); wr_byte(8'h66, 1, 1);
        ticks(160);
        n_ex = 0; push_flag();
        fb[0] = 8'h55; fb[1] = 8'h66; add_frame(2);
        pos = find_ex();
        chk(pos >= 0, "R8 short-packet abort ignored", pos, 0);
        chk(eop_cnt == 1, "R8 packet completes", eop_cnt, 1);

        // R9: write into full queue replaces newest; R12 hold while stalled
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) wr_byte(8'(8'h10 + i), 0, 0);
        wr_byte(8'hA5, 1, 0);
        ticks(5);
        chk(tx_bit === 1'b1 && n_cap == 0, "R12 line holds without bit_en", n_cap, 0);
        @(negedge clk); bit_en = 1;
        ticks(DEPTH * 12 + 120);
        n_ex = 0; push_flag();
        for (int i = 0; i < DEPTH - 1; i++) fb[i] = 8'(8'h10 + i);
        fb[DEPTH-1] = 8'hA5;
        add_frame(DEPTH);
        pos = find_ex();
        chk(pos >= 0, "R9 newest entry overwritten when full", pos, 0);

        // R10: flag idle, packet follows a flag directly
        do_reset(1'b1, 1'b0, 1'b1);
        ticks(48);
        n_ex = 0; push_flag(); push_flag(); push_flag();
        pos = find_ex();
        chk(pos >= 0, "R10 repeated flags when idle", pos, 0);
        wr_byte(8'h81, 1, 0);
        ticks(100);
        n_ex = 0; push_flag();
        fb[0] = 8'h81; add_frame(1); push_flag();
        pos = find_ex();
        chk(pos >= 0, "R10 packet between idle flags", pos, 0);
        chk(eop_cnt == 1, "R10 eop_sent in flag idle", eop_cnt, 1);

        // R11: transparent mode
        do_reset(1'b0, 1'b1, 1'b1);
        wr_byte(8'hFF, 0, 0); wr_byte(8'hFF, 0, 0);
        wr_byte(8'h00, 0, 0); wr_byte(8'hC3, 0, 0);
        ticks(120);
        n_ex = 0; push_raw(8'hFF); push_raw(8'hFF); push_raw(8'h00); push_raw(8'hC3);
        pos = find_ex();
        chk(pos >= 0, "R11 raw bytes without stuffing", pos, 0);
        n_ex = 0; push_flag();
        pos = find_ex();
        chk(pos < 0, "R11 no flag in transparent stream", pos, -1);
        chk(eop_cnt == 0 && uf_cnt == 0, "R11 no status pulses", eop_cnt + uf_cnt, 0);
        chk(tail_ones(24), "R11 ones when queue empty", n_cap, 24);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule